// File: doc/BRIEF.md
# Supply Fault Interrupt Supervisor

The block watches a digitized supply-voltage code and classifies it into one of four bands: normal, under-voltage, over-voltage and power-on reset. Each band has its own entry and release thresholds. Every time the supply enters or leaves a fault band, the block pulls an active-low interrupt. It also sets a sticky flag in a small interrupt status word and updates a live condition bit for that fault.

During any fault the block holds the switch-monitoring engine and its current sources off. When the supply returns to the normal band, it issues a one-cycle polling restart. At the end of the first polling pass after that restart, it raises a switch-state-change flag and tells the engine to take the detected switch states as its new baseline.

Flags are cleared only when chip-select rises at the end of a transaction in which the status word was read. A supply level below the reset threshold returns every flag and live bit to its default.

Top module: `supply_fault_supervisor`

## Requirements
- R1: Over-voltage starts when `supply_code` is strictly greater than `OV_RISE`. It ends when the code falls strictly below `OV_RISE - OV_HYST`; codes from that level up to `OV_RISE` keep the current state.
- R2: `mon_en` is high only in the normal band. It is low during under-voltage, over-voltage and power-on reset.
- R3: On entering under-voltage or over-voltage, `int_n` goes low. The matching flag is set in `int_stat`: bit 0 for under-voltage, bit 1 for over-voltage. The matching live bit (`uv_stat` or `ov_stat`) goes to 1.
- R4: `oor_flag` is high exactly while `int_stat` bit 0 or bit 1 is set.
- R5: On leaving under-voltage or over-voltage, `int_n` goes low, the matching `int_stat` flag is set and the matching live bit goes to 0.
- R6: Under-voltage starts when the code is strictly below `UV_FALL`. It ends when the code reaches `UV_RISE` or higher.
- R7: Entering the normal band gives a one-cycle `poll_restart` pulse.
  - The first `poll_done` after that pulse sets `int_stat` bit 2 (switch-state change) and gives a one-cycle `baseline_load` pulse.
  - Any later `poll_done` has no effect until the next restart.
- R8: `int_stat` is cleared on a rising edge of `cs_n`, but only if `rd_stb` was sampled high while `cs_n` was low in that transaction. A rising edge of `cs_n` with no such read leaves `int_stat` unchanged.
- R9: A code strictly below `POR_FALL` enters power-on reset.
  - This has priority over under-voltage.
  - `por_active` is high, `int_stat` and both live bits are 0, and `int_n` is high.
  - The state is left when the code reaches `POR_RISE`, going to the band the code then lies in.
- R10: An event that lands on the clearing edge is kept in `int_stat`. While a fault persists after its flag has been cleared, no further interrupt is raised.
- R11: Every output reflects a supply code or control input one clock edge after that input is sampled, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block starts in power-on reset |
| supply_code | input | CODE_W | Digitized supply voltage |
| cs_n | input | 1 | Serial chip-select, active low |
| rd_stb | input | 1 | Strobe marking a read of the interrupt status word |
| poll_done | input | 1 | End of a polling pass from the monitoring engine |
| int_n | output | 1 | Interrupt, active low, low while any `int_stat` flag is set |
| int_stat | output | 3 | Sticky flags: bit 0 under-voltage, bit 1 over-voltage, bit 2 switch-state change |
| uv_stat | output | 1 | Live under-voltage condition |
| ov_stat | output | 1 | Live over-voltage condition |
| oor_flag | output | 1 | Out-of-range indicator sent with each serial transaction |
| por_active | output | 1 | Power-on reset band active |
| mon_en | output | 1 | Enable for switch monitoring and current sources |
| poll_restart | output | 1 | One-cycle command to restart polling from the first enabled channel |
| baseline_load | output | 1 | One-cycle command to latch the detected switch states as the baseline |

## Verification
Every result is registered, so each one is due exactly one rising edge after the input that causes it: band changes, flags, live bits, the restart pulse, the baseline pulse and the clear on chip-select. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which falls after exactly one rising edge. One check samples just before that rising edge to confirm that nothing has moved early. The two one-cycle pulses are also checked one cycle later to confirm they have dropped.

// File: rtl/supply_fault_supervisor.sv
module supply_fault_supervisor #(
  parameter int CODE_W   = 10,
  parameter int OV_RISE  = 800,
  parameter int OV_HYST  = 40,
  parameter int UV_FALL  = 300,
  parameter int UV_RISE  = 340,
  parameter int POR_FALL = 200,
  parameter int POR_RISE = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] supply_code,
  input  logic              cs_n,
  input  logic              rd_stb,
  input  logic              poll_done,
  output logic              int_n,
  output logic [2:0]        int_stat,
  output logic              uv_stat,
  output logic              ov_stat,
  output logic              oor_flag,
  output logic              por_active,
  output logic              mon_en,
  output logic              poll_restart,
  output logic              baseline_load
);

  localparam logic [CODE_W-1:0] T_OV_HI  = CODE_W'(OV_RISE);
  localparam logic [CODE_W-1:0] T_OV_LO  = CODE_W'(OV_RISE - OV_HYST);
  localparam logic [CODE_W-1:0] T_UV_LO  = CODE_W'(UV_FALL);
  localparam logic [CODE_W-1:0] T_UV_HI  = CODE_W'(UV_RISE);
  localparam logic [CODE_W-1:0] T_POR_LO = CODE_W'(POR_FALL);
  localparam logic [CODE_W-1:0] T_POR_HI = CODE_W'(POR_RISE);

  typedef enum logic [1:0] {S_NORM, S_UV, S_OV, S_POR} band_t;

  band_t st, nxt;
  logic  cs_q, rd_seen, wait_base;
  logic  cs_rise, clr, uv_ev, ov_ev, rec, ssc_ev;

  always_comb begin
    nxt = st;
    if (supply_code < T_POR_LO) nxt = S_POR;
    else begin
      case (st)
        S_POR:  if (supply_code >= T_POR_HI)
                  nxt = (supply_code < T_UV_HI) ? S_UV :
                        (supply_code > T_OV_HI) ? S_OV : S_NORM;
        S_NORM: if (supply_code > T_OV_HI) nxt = S_OV;
                else if (supply_code < T_UV_LO) nxt = S_UV;
        S_UV:   if (supply_code >= T_UV_HI)
                  nxt = (supply_code > T_OV_HI) ? S_OV : S_NORM;
        S_OV:   if (supply_code < T_OV_LO)
                  nxt = (supply_code < T_UV_LO) ? S_UV : S_NORM;
        default: nxt = S_POR;
      endcase
    end
  end

  assign uv_ev   = (nxt != S_POR) && ((st == S_UV) != (nxt == S_UV));
  assign ov_ev   = (nxt != S_POR) && ((st == S_OV) != (nxt == S_OV));
  assign rec     = (nxt == S_NORM) && (st != S_NORM);
  assign ssc_ev  = wait_base && poll_done && (st == S_NORM) && (nxt == S_NORM);
  assign cs_rise = cs_n && !cs_q;
  assign clr     = cs_rise && rd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_POR;
      int_stat      <= '0;
      cs_q          <= 1'b1;
      rd_seen       <= 1'b0;
      wait_base     <= 1'b0;
      poll_restart  <= 1'b0;
      baseline_load <= 1'b0;
    end else begin
      st            <= nxt;
      cs_q          <= cs_n;
      poll_restart  <= rec;
      baseline_load <= ssc_ev;
      if (nxt == S_POR) int_stat <= '0;
      else int_stat <= (clr ? 3'b000 : int_stat) | {ssc_ev, ov_ev, uv_ev};
      if (cs_rise) rd_seen <= 1'b0;
      else if (rd_stb && !cs_n) rd_seen <= 1'b1;
      if (rec) wait_base <= 1'b1;
      else if (ssc_ev || nxt != S_NORM) wait_base <= 1'b0;
    end
  end

  assign int_n      = ~|int_stat;
  assign oor_flag   = |int_stat[1:0];
  assign uv_stat    = (st == S_UV);
  assign ov_stat    = (st == S_OV);
  assign por_active = (st == S_POR);
  assign mon_en     = (st == S_NORM);

endmodule

// File: rtl/supply_fault_supervisor_chk.sv
module supply_fault_supervisor_chk #(
  parameter int CODE_W  = 10,
  parameter int OV_RISE = 800,
  parameter int OV_HYST = 40,
  parameter int UV_RISE = 340
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] supply_code,
  input logic              int_n,
  input logic [2:0]        int_stat,
  input logic              uv_stat,
  input logic              ov_stat,
  input logic              oor_flag,
  input logic              por_active,
  input logic              mon_en,
  input logic              poll_restart
);
  localparam logic [CODE_W-1:0] C_OV_LO = CODE_W'(OV_RISE - OV_HYST);
  localparam logic [CODE_W-1:0] C_UV_HI = CODE_W'(UV_RISE);

  AST_OV_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    ov_stat |-> $past(supply_code) >= C_OV_LO); // R1
  AST_MON_OFF_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_stat || ov_stat || por_active) |-> !mon_en); // R2
  AST_OV_ENTRY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_stat) |-> (!int_n && int_stat[1])); // R3
  AST_OOR_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
    oor_flag |-> !int_n); // R4
  AST_OV_EXIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ov_stat) && !por_active) |-> (!int_n && int_stat[1])); // R5
  AST_UV_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    uv_stat |-> $past(supply_code) < C_UV_HI); // R6
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_restart |=> !poll_restart); // R7
  AST_RESTART_ON_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mon_en) |-> poll_restart); // R7
  AST_POR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |-> (int_stat == 3'b000 && int_n && !uv_stat && !ov_stat)); // R9
endmodule

bind supply_fault_supervisor supply_fault_supervisor_chk #(
  .CODE_W(CODE_W), .OV_RISE(OV_RISE), .OV_HYST(OV_HYST), .UV_RISE(UV_RISE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .int_n(int_n),
  .int_stat(int_stat), .uv_stat(uv_stat), .ov_stat(ov_stat),
  .oor_flag(oor_flag), .por_active(por_active), .mon_en(mon_en),
  .poll_restart(poll_restart)
);

// File: tb/supply_fault_supervisor_bench.sv
module supply_fault_supervisor_bench;
  localparam int CODE_W = 10;
  localparam int NV = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CODE_W-1:0] supply_code = 10'd500;
  logic cs_n = 1'b1, rd_stb = 1'b0, poll_done = 1'b0;
  logic int_n, uv_stat, ov_stat, oor_flag, por_active, mon_en, poll_restart, baseline_load;
  logic [2:0] int_stat;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  supply_fault_supervisor u_supply_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .cs_n(cs_n),
    .rd_stb(rd_stb), .poll_done(poll_done), .int_n(int_n), .int_stat(int_stat),
    .uv_stat(uv_stat), .ov_stat(ov_stat), .oor_flag(oor_flag),
    .por_active(por_active), .mon_en(mon_en), .poll_restart(poll_restart),
    .baseline_load(baseline_load)
  );

  // code[14:5] uv[4] ov[3] por[2] mon[1] int_n[0]
  localparam logic [14:0] VEC [NV] = '{
    {10'd500, 5'b00011}, {10'd800, 5'b00011}, {10'd801, 5'b01000},
    {10'd760, 5'b01000}, {10'd759, 5'b00010}, {10'd300, 5'b00010},
    {10'd299, 5'b10000}, {10'd339, 5'b10000}, {10'd340, 5'b00010},
    {10'd250, 5'b10000}, {10'd199, 5'b00101}, {10'd239, 5'b00101},
    {10'd240, 5'b10000}, {10'd500, 5'b00010}, {10'd900, 5'b01000},
    {10'd100, 5'b00101}, {10'd500, 5'b00011}, {10'd150, 5'b00101},
    {10'd500, 5'b00011}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_txn();
    cs_n = 1'b0; step();
    rd_stb = 1'b1; step();
    rd_stb = 1'b0; step();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset por_active", int'(por_active), 1);
    check("R9 reset int_n", int'(int_n), 1);
    check("R2 reset mon_en", int'(mon_en), 0);
    check("R9 reset int_stat", int'(int_stat), 0);
    rst_n = 1'b1;
    step();
    check("R7 restart after power-up", int'(poll_restart), 1);
    check("R2 mon_en after power-up", int'(mon_en), 1);

    for (int i = 0; i < NV; i++) begin
      supply_code = VEC[i][14:5];
      step();
      check("R6 uv_stat (R9 priority)", int'(uv_stat), int'(VEC[i][4]));
      check("R1 ov_stat", int'(ov_stat), int'(VEC[i][3]));
      check("R9 por_active", int'(por_active), int'(VEC[i][2]));
      check("R2 mon_en", int'(mon_en), int'(VEC[i][1]));
      check("R3 R5 int_n", int'(int_n), int'(VEC[i][0]));
    end

    poll_done = 1'b1; step();
    check("R7 ssc flag", int'(int_stat), 4);
    check("R7 baseline_load", int'(baseline_load), 1);
    check("R7 int_n on ssc", int'(int_n), 0);
    poll_done = 1'b0; step();
    check("R7 baseline pulse ends", int'(baseline_load), 0);
    poll_done = 1'b1; step();
    check("R7 second poll_done ignored", int'(baseline_load), 0);
    poll_done = 1'b0;

    cs_n = 1'b0; step(); step();
    cs_n = 1'b1; step();
    check("R8 no clear without read", int'(int_stat), 4);

    read_txn();
    cs_n = 1'b1; step();
    check("R8 clear after read", int'(int_stat), 0);
    check("R8 int_n released", int'(int_n), 1);

    supply_code = 10'd900;
    #5;
    check("R11 no early change", int'(ov_stat), 0);
    step();
    check("R3 ov flag", int'(int_stat), 2);
    check("R4 oor_flag set", int'(oor_flag), 1);
    check("R3 ov_stat", int'(ov_stat), 1);
    check("R2 mon_en off in ov", int'(mon_en), 0);
    read_txn();
    cs_n = 1'b1; step();
    check("R8 ov flag cleared", int'(int_stat), 0);
    check("R4 oor_flag clear", int'(oor_flag), 0);
    repeat (5) step();
    check("R10 no repeat interrupt", int'(int_n), 1);
    check("R10 fault persists", int'(ov_stat), 1);

    read_txn();
    cs_n = 1'b1; supply_code = 10'd700; step();
    check("R10 event kept at clear", int'(int_stat), 2);
    check("R5 int_n on exit", int'(int_n), 0);
    check("R5 ov_stat cleared", int'(ov_stat), 0);
    check("R7 restart on recovery", int'(poll_restart), 1);
    step();
    check("R7 restart one cycle", int'(poll_restart), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule